// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block turns pairs of 24-bit audio samples into a single serial bit stream. A word-select output marks which channel occupies the current slot, and the data line changes once per bit period. The system clock runs faster than the bit rate. An outside clock generator supplies a one-cycle strobe, `bit_tick`, that stands for each falling edge of the bit clock. Every strobe moves the serial output and word select forward by one bit.

Software feeds the block through a small write port. The port has three targets: a left data register, a right data register and a control register. The control register sets the slot length (16, 24 or 32 bits). It also sets how the 8 spare bits of a 32-bit slot are filled, and whether interrupt requests are enabled.

At the start of each slot, the block copies the matching data register into its output word and raises that channel's empty flag. The two empty flags are combined into three separate requests: left, right and underrun. The requests pass through a registered copy of the enable. A software reset input returns the control and the framing to their reset state without a hardware reset.

Top module: `stereo_ser_tx`

## Requirements
- R1: After hardware reset, `sdo` is 0 and `ws` is 1. Both empty flags are 1, all three requests are 0, and the control register is cleared.
- R2: Data leaves MSB first. `ws` is 0 during the left slot and 1 during the right slot. Word-length codes 01 and 11 select 24-bit slots that carry the whole sample.
- R3: Word-length code 00 selects 16-bit slots that carry bits 23 down to 8 of the sample.
- R4: Word-length code 10 with expansion 0 gives a 32-bit slot: the 24 sample bits, then bit 0 repeated 8 times.
- R5: Word-length code 10 with expansion 1 gives a 32-bit slot: bit 23 repeated 8 times, then the 24 sample bits.
- R6: The expansion bit has no effect when the word-length code is not 10.
- R7: A write to the left register (select 0) or the right register (select 1) clears that channel's empty flag at the next edge. A write in the same cycle as a load wins. The flag sets again when that register is loaded at the start of its slot.
- R8: The empty flags follow R7 whatever the value of the interrupt enable.
- R9: With the enable active, a left request is raised when only the left flag is set, and a right request when only the right flag is set. At most one request is high at a time.
- R10: With the enable active and both flags set, only the underrun request is raised, and the last loaded samples are sent again unchanged.
- R11: The enable reaches the request outputs one cycle after the control register. A request therefore stays visible for one cycle after a write that clears the enable.
- R12: A software reset pulse clears the control register, including the expansion bit. It sets both empty flags, sets `ws` to 1 and `sdo` to 0, and makes the next strobe start a left slot.
- R13: `sdo` and `ws` change only on a cycle with `bit_tick` high, or on a software reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset pulse |
| bit_tick | input | 1 | One-cycle strobe for each falling edge of the bit clock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 left data, 1 right data, 2 control (bit 3 enable, bit 2 expansion, bits 1:0 word length), 3 none |
| wr_data | input | SAMPLE_W | Write data |
| sdo | output | 1 | Serial data out |
| ws | output | 1 | Word select, 0 left, 1 right |
| left_empty | output | 1 | Left data register empty |
| right_empty | output | 1 | Right data register empty |
| irq_left | output | 1 | Left channel request |
| irq_right | output | 1 | Right channel request |
| irq_underrun | output | 1 | Underrun request |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 16-bit short slots and 8 pad bits. With these values all three slot lengths and both pad placements are reachable. A monitor rebuilds each slot from the serial stream, and each rebuilt slot is compared with a value computed from the requirement for that mode. A manual strobe puts the framing in a known place, which allows exact cycle checks of the request encoding and of the one-cycle enable delay.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_24  = 2'b01,
    WL_32  = 2'b10,
    WL_RSV = 2'b11
  } wlen_e;

  typedef enum logic [1:0] {
    SEL_LEFT  = 2'd0,
    SEL_RIGHT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;

  typedef struct packed {
    logic  ie;
    logic  expand;
    wlen_e wlen;
  } ctrl_t;

endpackage

// File: rtl/stx_regs.sv
module stx_regs
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                load_left,
  input  logic                load_right,
  output logic [SAMPLE_W-1:0] left_word,
  output logic [SAMPLE_W-1:0] right_word,
  output ctrl_t               ctrl,
  output logic                left_empty,
  output logic                right_empty,
  output logic                ie_q
);

  localparam int CTRL_W = $bits(ctrl_t);

  logic [SAMPLE_W-1:0] left_q, left_d, right_q, right_d;
  ctrl_t               ctrl_q, ctrl_d;
  logic                le_q, le_d, re_q, re_d, ie_d;

  always_comb begin
    left_d  = left_q;
    right_d = right_q;
    ctrl_d  = ctrl_q;
    le_d    = le_q;
    re_d    = re_q;
    if (load_left)  le_d = 1'b1;
    if (load_right) re_d = 1'b1;
    if (wr_en) begin
      case (wr_sel)
        SEL_LEFT:  begin left_d  = wr_data; le_d = 1'b0; end
        SEL_RIGHT: begin right_d = wr_data; re_d = 1'b0; end
        SEL_CTRL:  ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
        default:   ;
      endcase
    end
    ie_d = ctrl_q.ie;
    if (soft_rst) begin
      ctrl_d = '0;
      le_d   = 1'b1;
      re_d   = 1'b1;
      ie_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      ctrl_q  <= '0;
      le_q    <= 1'b1;
      re_q    <= 1'b1;
      ie_q    <= 1'b0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
      ctrl_q  <= ctrl_d;
      le_q    <= le_d;
      re_q    <= re_d;
      ie_q    <= ie_d;
    end
  end

  assign left_word   = left_q;
  assign right_word  = right_q;
  assign ctrl        = ctrl_q;
  assign left_empty  = le_q;
  assign right_empty = re_q;

endmodule

// File: rtl/stx_serializer.sv
module stx_serializer
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int EXT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                bit_tick,
  input  wlen_e               wlen,
  input  logic                expand,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  output logic                sdo,
  output logic                ws,
  output logic                load_left,
  output logic                load_right
);

  localparam int LONG_W = SAMPLE_W + EXT_W;
  localparam int CNT_W  = $clog2(LONG_W);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
  localparam logic [CNT_W-1:0] EXT_C      = CNT_W'(EXT_W);
  localparam logic [CNT_W-1:0] MID_C      = CNT_W'(SAMPLE_W);

  logic [CNT_W-1:0]    cnt_q, cnt_d, last_idx, pos;
  logic                ws_q, ws_d, sdo_q, sdo_d, slot_end, step, out_bit;
  logic [SAMPLE_W-1:0] word_q, word_d, cur_w, sh_main, sh_late;

  always_comb begin
    case (wlen)
      WL_16:   last_idx = LAST_SHORT;
      WL_32:   last_idx = LAST_LONG;
      default: last_idx = LAST_MID;
    endcase
  end

  assign slot_end = (cnt_q >= last_idx);
  assign step     = bit_tick && !soft_rst;

  // slot position and the word that drives it
  always_comb begin
    pos        = cnt_q;
    cur_w      = word_q;
    load_left  = 1'b0;
    load_right = 1'b0;
    if (step) begin
      if (slot_end) begin
        pos        = '0;
        cur_w      = ws_q ? left_word : right_word;
        load_left  = ws_q;
        load_right = !ws_q;
      end else begin
        pos = cnt_q + 1'b1;
      end
    end
  end

  // bit selection for the current slot position
  always_comb begin
    sh_main = cur_w << pos;
    sh_late = cur_w << (pos - EXT_C);
    if (wlen == WL_32) begin
      if (expand) out_bit = (pos < EXT_C) ? cur_w[SAMPLE_W-1] : sh_late[SAMPLE_W-1];
      else        out_bit = (pos < MID_C) ? sh_main[SAMPLE_W-1] : cur_w[0];
    end else begin
      out_bit = sh_main[SAMPLE_W-1];
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    ws_d   = ws_q;
    word_d = word_q;
    sdo_d  = sdo_q;
    if (soft_rst) begin
      cnt_d = '1;
      ws_d  = 1'b1;
      sdo_d = 1'b0;
    end else if (step) begin
      cnt_d  = pos;
      word_d = cur_w;
      sdo_d  = out_bit;
      if (slot_end) ws_d = !ws_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      ws_q   <= 1'b1;
      sdo_q  <= 1'b0;
      word_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ws_q   <= ws_d;
      sdo_q  <= sdo_d;
      word_q <= word_d;
    end
  end

  assign sdo = sdo_q;
  assign ws  = ws_q;

endmodule

// File: rtl/stx_irq.sv
module stx_irq (
  input  logic ie_q,
  input  logic left_empty,
  input  logic right_empty,
  output logic irq_left,
  output logic irq_right,
  output logic irq_underrun
);

  always_comb begin
    irq_left     = ie_q &&  left_empty && !right_empty;
    irq_right    = ie_q && !left_empty &&  right_empty;
    irq_underrun = ie_q &&  left_empty &&  right_empty;
  end

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16,
  parameter int EXT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                bit_tick,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                sdo,
  output logic                ws,
  output logic                left_empty,
  output logic                right_empty,
  output logic                irq_left,
  output logic                irq_right,
  output logic                irq_underrun
);

  logic [SAMPLE_W-1:0] left_word, right_word;
  ctrl_t               ctrl;
  logic                load_left, load_right, ie_q;

  stx_regs #(.SAMPLE_W(SAMPLE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .load_left  (load_left),
    .load_right (load_right),
    .left_word  (left_word),
    .right_word (right_word),
    .ctrl       (ctrl),
    .left_empty (left_empty),
    .right_empty(right_empty),
    .ie_q       (ie_q)
  );

  stx_serializer #(
    .SAMPLE_W(SAMPLE_W),
    .SHORT_W (SHORT_W),
    .EXT_W   (EXT_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .bit_tick  (bit_tick),
    .wlen      (ctrl.wlen),
    .expand    (ctrl.expand),
    .left_word (left_word),
    .right_word(right_word),
    .sdo       (sdo),
    .ws        (ws),
    .load_left (load_left),
    .load_right(load_right)
  );

  stx_irq u_irq (
    .ie_q        (ie_q),
    .left_empty  (left_empty),
    .right_empty (right_empty),
    .irq_left    (irq_left),
    .irq_right   (irq_right),
    .irq_underrun(irq_underrun)
  );

endmodule

// File: rtl/stx_tx_checker.sv
module stx_tx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst,
  input logic                bit_tick,
  input logic                wr_en,
  input logic [1:0]          wr_sel,
  input logic [SAMPLE_W-1:0] wr_data,
  input logic                sdo,
  input logic                ws,
  input logic                left_empty,
  input logic                right_empty,
  input logic                irq_left,
  input logic                irq_right,
  input logic                irq_underrun
);

  assert_line_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !soft_rst) |=> ($stable(ws) && $stable(sdo)));

  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_left, irq_right, irq_underrun}));

  assert_underrun_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_underrun |-> (left_empty && right_empty));

  assert_left_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && !soft_rst) |=> !left_empty);

  assert_right_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && !soft_rst) |=> !right_empty);

  assert_enable_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && wr_sel == 2'd2 && !wr_data[3]) ##1 !(wr_en && wr_sel == 2'd2))
      |=> !(irq_left || irq_right || irq_underrun));

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ws && !sdo && left_empty && right_empty &&
                  !(irq_left || irq_right || irq_underrun)));

endmodule

bind stereo_ser_tx stx_tx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .bit_tick    (bit_tick),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .sdo         (sdo),
  .ws          (ws),
  .left_empty  (left_empty),
  .right_empty (right_empty),
  .irq_left    (irq_left),
  .irq_right   (irq_right),
  .irq_underrun(irq_underrun)
);

// File: tb/tb_stereo_ser_tx.sv
`timescale 1ns/1ps
module tb_stereo_ser_tx;

  localparam int SW = 24;
  localparam int NV = 7;
  // {word length, expansion, left sample, right sample}
  localparam logic [50:0] VEC [NV] = '{
    {2'b01, 1'b0, 24'hA5C3F1, 24'h0F1E2D},
    {2'b00, 1'b0, 24'hBEEF12, 24'h123456},
    {2'b10, 1'b0, 24'h800001, 24'h7FFFFE},
    {2'b10, 1'b1, 24'h800001, 24'h7FFFFE},
    {2'b01, 1'b1, 24'hC0FFEE, 24'h31337A},
    {2'b00, 1'b1, 24'hDEAD55, 24'h5A5A5A},
    {2'b11, 1'b1, 24'h13579B, 24'h2468AC}
  };

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic tick_auto = 1'b0, tick_man = 1'b0, tick_en = 1'b0, mon_clr = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [SW-1:0] wr_data = '0;
  logic bit_tick;
  logic sdo, ws, left_empty, right_empty, irq_left, irq_right, irq_underrun;

  int checks = 0, fails = 0;

  assign bit_tick = tick_auto | tick_man;

  stereo_ser_tx dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sdo(sdo), .ws(ws), .left_empty(left_empty), .right_empty(right_empty),
    .irq_left(irq_left), .irq_right(irq_right), .irq_underrun(irq_underrun)
  );

  always #2 clk = ~clk;

  always @(negedge clk) tick_auto <= tick_en && !tick_auto;

  // slot monitor: rebuilds each slot from the serial stream
  logic tick_seen = 1'b0;
  logic mon_ws = 1'b1;
  logic [63:0] acc = '0;
  int cnt = 0;
  logic [63:0] slot_val [2];
  int slot_len [2];
  int done_cnt = 0;

  always @(posedge clk) tick_seen <= bit_tick && rst_n && !soft_rst;

  always @(negedge clk) begin
    if (mon_clr) begin
      mon_ws = 1'b1; acc = '0; cnt = 0;
    end else if (tick_seen) begin
      if (ws != mon_ws) begin
        if (cnt > 0) begin
          slot_val[mon_ws] = acc;
          slot_len[mon_ws] = cnt;
          done_cnt++;
        end
        acc = {63'b0, sdo}; cnt = 1; mon_ws = ws;
      end else begin
        acc = {acc[62:0], sdo}; cnt++;
      end
    end
  end

  function automatic logic [63:0] exp_val(logic [1:0] wl, logic ex, logic [SW-1:0] w);
    case (wl)
      2'b00:   return {48'b0, w[23:8]};
      2'b10:   return ex ? {32'b0, {8{w[23]}}, w} : {32'b0, w, {8{w[0]}}};
      default: return {40'b0, w};
    endcase
  endfunction

  function automatic int exp_len(logic [1:0] wl);
    case (wl)
      2'b00:   return 16;
      2'b10:   return 32;
      default: return 24;
    endcase
  endfunction

  function automatic string tag(logic [1:0] wl, logic ex);
    if (wl == 2'b00) return ex ? "R3/R6" : "R3";
    if (wl == 2'b10) return ex ? "R5" : "R4";
    return ex ? "R2/R6" : "R2";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [SW-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic wait_slots(int n);
    int target = done_cnt + n;
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic pulse_soft_rst();
    soft_rst = 1'b1; mon_clr = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; mon_clr = 1'b0;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [1:0] wl;
    logic ex;
    logic [SW-1:0] lw, rw;
    logic ws_hold, sdo_hold;
    logic [63:0] last_left;
    int guard;

    // R1: reset state
    mon_clr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {58'b0, sdo, ws, left_empty, right_empty, irq_left, irq_right | irq_underrun},
        {58'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    rst_n = 1'b1; mon_clr = 1'b0;
    @(negedge clk);
    tick_en = 1'b1;

    // vector table walk: R2..R6
    for (int i = 0; i < NV; i++) begin
      {wl, ex, lw, rw} = VEC[i];
      wr(2'd2, {20'b0, 1'b0, ex, wl});
      wr(2'd0, lw);
      wr(2'd1, rw);
      wait_slots(5);
      chk({tag(wl, ex), " left slot"},  slot_val[0], exp_val(wl, ex, lw));
      chk({tag(wl, ex), " right slot"}, slot_val[1], exp_val(wl, ex, rw));
      chk({tag(wl, ex), " slot length"}, 64'(slot_len[0]), 64'(exp_len(wl)));
    end

    // R10: old data resent, R8: flags set with enable clear
    last_left = slot_val[0];
    wait_slots(4);
    chk("R10 resend left", slot_val[0], last_left);
    chk("R8 flags with enable off", {62'b0, left_empty, right_empty}, 64'd3);
    chk("R8 no requests with enable off", {61'b0, irq_left, irq_right, irq_underrun}, 64'd0);

    // R7: write clears flag, load sets it again
    wr(2'd0, 24'h0A0B0C);
    chk("R7 write clears left flag", {63'b0, left_empty}, 64'd0);
    guard = 0;
    while (!left_empty && guard < 200) begin @(negedge clk); guard++; end
    chk("R7 left flag sets on load", {63'b0, left_empty}, 64'd1);

    // R13: lines hold without strobes
    tick_en = 1'b0;
    @(negedge clk); @(negedge clk);
    ws_hold = ws; sdo_hold = sdo;
    repeat (10) @(negedge clk);
    chk("R13 lines stable without tick", {62'b0, ws, sdo}, {62'b0, ws_hold, sdo_hold});

    // R12: soft reset state
    wr(2'd2, {20'b0, 1'b0, 1'b1, 2'b10});
    pulse_soft_rst();
    chk("R12 soft reset state", {60'b0, ws, sdo, left_empty, right_empty}, {60'b0, 1'b1, 1'b0, 1'b1, 1'b1});

    // R11/R10: enable delay and underrun
    wr(2'd2, {20'b0, 1'b1, 1'b0, 2'b01});
    chk("R11 enable not yet applied", {61'b0, irq_left, irq_right, irq_underrun}, 64'd0);
    @(negedge clk);
    chk("R10 underrun request", {61'b0, irq_left, irq_right, irq_underrun}, 64'd1);
    wr(2'd0, 24'hC35A00);
    chk("R9 right request", {61'b0, irq_left, irq_right, irq_underrun}, 64'd2);
    wr(2'd1, 24'h112233);
    chk("R9 no request when both full", {61'b0, irq_left, irq_right, irq_underrun}, 64'd0);
    tick_man = 1'b1;
    @(negedge clk);
    tick_man = 1'b0;
    chk("R9 left request after left load", {61'b0, irq_left, irq_right, irq_underrun}, 64'd4);
    chk("R2 left slot ws low, MSB first", {62'b0, ws, sdo}, {62'b0, 1'b0, 1'b1});
    wr(2'd2, {20'b0, 1'b0, 1'b0, 2'b01});
    chk("R11 request held one cycle", {63'b0, irq_left}, 64'd1);
    @(negedge clk);
    chk("R11 request masked", {61'b0, irq_left, irq_right, irq_underrun}, 64'd0);

    // R12: control cleared gives 16-bit slots
    wr(2'd2, {20'b0, 1'b0, 1'b1, 2'b10});
    pulse_soft_rst();
    tick_en = 1'b1;
    wait_slots(4);
    chk("R12 cleared control 16-bit slot", slot_val[0], exp_val(2'b00, 1'b0, 24'hC35A00));
    chk("R12 cleared control slot length", 64'(slot_len[0]), 64'd16);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule